// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It walks the memory through the mandatory power-up sequence before any normal traffic. It holds the clock-enable low during a long settling wait, then brings it high and places one idle cycle on the command bus. It then issues a fixed series of commands, and each command is followed by the minimum number of idle cycles that the memory needs. The block drives the clock-enable, the four command pins, the bank-select field and the address field.

The block has two flags. `init_done` rises once the last mode-register write has settled. `read_ok` is a separate flag. It also waits until the DLL has had a fixed number of cycles to lock after its reset, because that lock time can run past the end of the command series.

The operating bits of the mode register and the output-drive choice come in as inputs. Both are sampled once, when the clock-enable is about to rise. All timing counts are parameters.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after any rising clock edge with `rst` high, the outputs are `cke`=0, `cs_n`=1, `init_done`=0 and `read_ok`=0. Releasing `rst` restarts the whole sequence.
- R2: After reset release, `cke` stays 0 for exactly STABLE_CYC cycles and the bus shows DESELECT (`cs_n`=1) during that time. `cke` then goes to 1, and exactly one NOP cycle appears before the first command.
- R3: Commands are encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`} as NOP=0111, PRECHARGE ALL=0010, AUTO REFRESH=0001 and LOAD MODE=0000, and each command lasts one cycle. The order is: PRECHARGE ALL, LOAD MODE (extended), LOAD MODE (DLL reset), PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, LOAD MODE (final).
- R4: Each PRECHARGE ALL is followed by exactly T_RP NOP cycles. Each LOAD MODE is followed by exactly T_MRD NOP cycles. Each AUTO REFRESH is followed by exactly T_RFC NOP cycles. No other bus value appears while `cke` is 1.
- R5: PRECHARGE ALL drives `addr` with only bit 10 set and `ba`=0. AUTO REFRESH and NOP drive `addr`=0 and `ba`=0.
- R6: The extended LOAD MODE drives `ba`=01, `addr[0]`=0 (DLL on), `addr[1]`=`drive_reduced`, and all other address bits 0.
- R7: The DLL-reset LOAD MODE drives `ba`=00 and `addr`=`mode_cfg` with bit 8 forced to 1. The final LOAD MODE drives `ba`=00 and the same value with bit 8 forced to 0, whatever bit 8 of `mode_cfg` is.
- R8: `mode_cfg` and `drive_reduced` are sampled in the last cycle that `cke` is 0. Changes to them after that point have no effect on the commands of that sequence.
- R9: `init_done` rises exactly T_MRD+1 cycles after the final LOAD MODE and stays high until reset.
- R10: `read_ok` rises exactly at the later of two cycles: DLL_CYC cycles after the DLL-reset LOAD MODE, or the cycle where `init_done` rises. It is never high while `init_done` is low.
- R11: Once `init_done` is high, the bus shows only NOP and `cke` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_cfg | input | ROW_W | Operating bits of the base mode register (bit 8 is overridden) |
| drive_reduced | input | 1 | 1 selects reduced output drive in the extended mode register |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank select |
| addr | output | ROW_W | Address bus |
| init_done | output | 1 | Initialization sequence finished |
| read_ok | output | 1 | Reads may be issued (DLL lock time met) |

## Verification
The bench records every command and every gap, and compares them with cycle counts computed from the timing parameters. A sequencer with an off-by-one wait loop therefore shows a gap one cycle wrong, and one that drops or repeats a step shows the wrong command count. The parameters make the DLL lock window longer than the tail of the sequence, so `read_ok` has to lag `init_done`; a design that ties the two flags together raises `read_ok` too early.

Random mode values include both settings of bit 8. This catches a design that copies that bit through instead of forcing it. The settings are inverted right after `cke` rises, which exposes a design that reads the live inputs instead of the sampled copy. An abort in the middle of the sequence checks that reset clears the outputs at once, and the run after it checks that the timers restart.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmd_e;

  typedef enum logic [2:0] {
    STP_PRE0,
    STP_EMR,
    STP_MR_DLL,
    STP_PRE1,
    STP_REF0,
    STP_REF1,
    STP_MR_FIN
  } step_e;

  typedef enum logic [2:0] {
    ST_CKE_LOW,
    ST_LEAD,
    ST_ISSUE,
    ST_GAP,
    ST_DONE
  } state_e;

endpackage

// File: rtl/ddr_init_wait.sv
module ddr_init_wait #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= CW'(RST_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4: a fresh gap is only loaded once the previous wait has fully elapsed
  p_load_when_idle_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> zero);

endmodule

// File: rtl/ddr_init_dll_timer.sv
module ddr_init_dll_timer #(
  parameter int DLL_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);

  localparam int CW = $clog2(DLL_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DLL_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = active_q && (cnt_q == LIM);

  // R10: once the lock window has run out it stays out until a new start
  p_expire_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (expired && !start) |=> expired);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int BA_W    = 2,
  parameter int PRE_BIT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_d,
  input  cmd_e             cmd_d,
  input  logic [BA_W-1:0]  ba_d,
  input  logic [ROW_W-1:0] addr_d,
  input  logic             done_d,
  input  logic             rd_d,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done,
  output logic             read_ok
);

  function automatic logic [3:0] pins_of(cmd_e c);
    case (c)
      CMD_NOP: pins_of = 4'b0111;
      CMD_PRE: pins_of = 4'b0010;
      CMD_REF: pins_of = 4'b0001;
      CMD_LMR: pins_of = 4'b0000;
      default: pins_of = 4'b1111;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cke                      <= 1'b0;
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      ba                       <= '0;
      addr                     <= '0;
      init_done                <= 1'b0;
      read_ok                  <= 1'b0;
    end else begin
      cke                      <= cke_d;
      {cs_n, ras_n, cas_n, we_n} <= pins_of(cmd_d);
      ba                       <= ba_d;
      addr                     <= addr_d;
      init_done                <= done_d;
      read_ok                  <= rd_d;
    end
  end

  logic is_cmd;
  assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);

  p_cke_low_desel_r2: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n);

  p_one_cycle_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> (!cs_n && ras_n && cas_n && we_n));

  p_pre_a10_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> (addr[PRE_BIT] && ba == '0));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_read_gate_r10: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> init_done);

  p_idle_after_done_r11: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && !is_cmd));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ROW_W       = 13,
  parameter int BA_W        = 2,
  parameter int STABLE_CYC  = 25000,
  parameter int T_RP        = 3,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 10,
  parameter int DLL_CYC     = 200,
  parameter int DLL_RST_BIT = 8,
  parameter int PRE_BIT     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROW_W-1:0] mode_cfg,
  input  logic             drive_reduced,
  output logic             cke,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr,
  output logic             init_done,
  output logic             read_ok
);

  localparam int MAX_GAP = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                          : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int MAX_V   = (STABLE_CYC > MAX_GAP) ? STABLE_CYC : MAX_GAP;
  localparam int CW      = $clog2(MAX_V + 1);
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);
  localparam logic [BA_W-1:0] BA_BASE = '0;

  state_e           state_q;
  step_e            step_q;
  logic [ROW_W-1:0] cfg_q;
  logic             drv_q;
  logic             wait_zero;
  logic             dll_expired;

  cmd_e             step_cmd;
  logic [BA_W-1:0]  step_ba;
  logic [ROW_W-1:0] step_addr;
  logic [CW-1:0]    step_gap;

  cmd_e             cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;
  logic             done_d;

  // sequence control
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CKE_LOW;
      step_q  <= STP_PRE0;
      cfg_q   <= '0;
      drv_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_CKE_LOW: if (wait_zero) begin
          state_q <= ST_LEAD;
          cfg_q   <= mode_cfg;
          drv_q   <= drive_reduced;
        end
        ST_LEAD:  state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_GAP;
        ST_GAP: if (wait_zero) begin
          if (step_q == STP_MR_FIN) begin
            state_q <= ST_DONE;
          end else begin
            step_q  <= step_e'(step_q + 3'd1);
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  // what each step puts on the bus and how long it must settle
  always_comb begin
    step_cmd  = CMD_NOP;
    step_ba   = '0;
    step_addr = '0;
    step_gap  = CW'(T_MRD);
    case (step_q)
      STP_PRE0, STP_PRE1: begin
        step_cmd           = CMD_PRE;
        step_addr[PRE_BIT] = 1'b1;
        step_gap           = CW'(T_RP);
      end
      STP_EMR: begin
        step_cmd     = CMD_LMR;
        step_ba      = BA_EXT;
        step_addr[1] = drv_q;
      end
      STP_MR_DLL: begin
        step_cmd               = CMD_LMR;
        step_ba                = BA_BASE;
        step_addr              = cfg_q;
        step_addr[DLL_RST_BIT] = 1'b1;
      end
      STP_REF0, STP_REF1: begin
        step_cmd = CMD_REF;
        step_gap = CW'(T_RFC);
      end
      STP_MR_FIN: begin
        step_cmd               = CMD_LMR;
        step_ba                = BA_BASE;
        step_addr              = cfg_q;
        step_addr[DLL_RST_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    cmd_d  = (state_q == ST_CKE_LOW) ? CMD_DESEL : CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (state_q == ST_ISSUE) begin
      cmd_d  = step_cmd;
      ba_d   = step_ba;
      addr_d = step_addr;
    end
  end

  assign done_d = (state_q == ST_DONE);

  ddr_init_wait #(
    .CW      (CW),
    .RST_VAL (STABLE_CYC - 1)
  ) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (state_q == ST_ISSUE),
    .load_val (step_gap - 1'b1),
    .zero     (wait_zero)
  );

  ddr_init_dll_timer #(
    .DLL_CYC (DLL_CYC)
  ) u_dll (
    .clk     (clk),
    .rst     (rst),
    .start   (state_q == ST_ISSUE && step_q == STP_MR_DLL),
    .expired (dll_expired)
  );

  ddr_init_cmd_enc #(
    .ROW_W   (ROW_W),
    .BA_W    (BA_W),
    .PRE_BIT (PRE_BIT)
  ) u_enc (
    .clk       (clk),
    .rst       (rst),
    .cke_d     (state_q != ST_CKE_LOW),
    .cmd_d     (cmd_d),
    .ba_d      (ba_d),
    .addr_d    (addr_d),
    .done_d    (done_d),
    .rd_d      (done_d && dll_expired),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done),
    .read_ok   (read_ok)
  );

  // R3: steps advance only through the gap state, never skipping ahead
  p_step_after_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ISSUE) |=> (state_q == ST_GAP && $stable(step_q)));

  // R8: sampled settings never move once the clock enable is up
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_CKE_LOW) |=> $stable(cfg_q) && $stable(drv_q));

  // R10: the sequence cannot finish without the DLL window having started
  p_dll_started_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |-> (u_dll.active_q));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int STB  = 40;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 9;
  localparam int DLL  = 200;
  localparam int RUN  = 420;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mode_cfg = '0;
  logic          drive_reduced = 1'b0;
  logic          cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .ROW_W(AW), .BA_W(BW), .STABLE_CYC(STB), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .DLL_CYC(DLL)
  ) u_ddr_init_seq (
    .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .drive_reduced(drive_reduced),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 deselect, 1 nop, 2 precharge all, 3 refresh, 4 load mode, 5 other
  function automatic int kind_of(logic c, logic r, logic a, logic w);
    if (c) return 0;
    case ({r, a, w})
      3'b111:  return 1;
      3'b010:  return 2;
      3'b001:  return 3;
      3'b000:  return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_kind(int i);
    case (i)
      0, 3:    return 2;
      4, 5:    return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int exp_gap(int i);
    case (i)
      0, 3:    return TRP;
      4, 5:    return TRFC;
      default: return TMRD;
    endcase
  endfunction

  function automatic int exp_ba(int i);
    return (i == 1) ? 1 : 0;
  endfunction

  function automatic int exp_addr(int i, logic [AW-1:0] cfg, logic drv);
    logic [AW-1:0] v;
    v = '0;
    case (i)
      0, 3: v[10] = 1'b1;
      1:    v[1]  = drv;
      2:    begin v = cfg; v[8] = 1'b1; end
      6:    begin v = cfg; v[8] = 1'b0; end
      default: v = '0;
    endcase
    return int'(v);
  endfunction

  task automatic reset_check();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(cke == 1'b0 && cs_n == 1'b1, "R1 reset bus", int'({cke, cs_n}), 1);
    chk(init_done == 1'b0 && read_ok == 1'b0, "R1 reset flags",
        int'({init_done, read_ok}), 0);
  endtask

  task automatic run_seq(input logic [AW-1:0] cfg, input logic drv, input bit flip);
    int cyc_a[16];
    int ba_a[16];
    int addr_a[16];
    int kind_a[16];
    int ncmd = 0, low_cnt = 0, lead = 0, bad_low = 0, bad_idle = 0;
    int done_cyc = -1, rd_cyc = -1, done_drop = 0, rd_early = 0;
    bit seen_high = 0;
    mode_cfg = cfg;
    drive_reduced = drv;
    reset_check();
    rst = 1'b0;
    for (int t = 1; t <= RUN; t++) begin
      int k;
      @(negedge clk);
      k = kind_of(cs_n, ras_n, cas_n, we_n);
      if (!seen_high) begin
        if (!cke) begin
          low_cnt++;
          if (k != 0) bad_low++;
        end else begin
          seen_high = 1;
          if (flip) begin
            mode_cfg = ~cfg;
            drive_reduced = ~drv;
          end
        end
      end
      if (seen_high) begin
        if (!cke) bad_idle++;
        else if (k == 1) begin
          if (ncmd == 0) lead++;
        end else if (k >= 2 && k <= 4) begin
          if (ncmd < 16) begin
            cyc_a[ncmd] = t; kind_a[ncmd] = k;
            ba_a[ncmd] = int'(ba); addr_a[ncmd] = int'(addr);
          end
          ncmd++;
        end else bad_idle++;
      end
      if (init_done && done_cyc < 0) done_cyc = t;
      if (!init_done && done_cyc >= 0) done_drop++;
      if (read_ok && rd_cyc < 0) rd_cyc = t;
      if (read_ok && !init_done) rd_early++;
    end
    chk(low_cnt == STB, "R2 cke low cycles", low_cnt, STB);
    chk(bad_low == 0, "R2 deselect while cke low", bad_low, 0);
    chk(lead == 1, "R2 lead nop", lead, 1);
    chk(ncmd == 7, "R3 command count", ncmd, 7);
    chk(bad_idle == 0, "R4/R11 non-nop idle", bad_idle, 0);
    if (ncmd == 7) begin
      for (int i = 0; i < 7; i++) begin
        chk(kind_a[i] == exp_kind(i), $sformatf("R3 kind step %0d", i), kind_a[i], exp_kind(i));
        chk(ba_a[i] == exp_ba(i), $sformatf("R6/R7 bank step %0d", i), ba_a[i], exp_ba(i));
        chk(addr_a[i] == exp_addr(i, cfg, drv),
            $sformatf("R5/R6/R7/R8 addr step %0d", i), addr_a[i], exp_addr(i, cfg, drv));
        if (i < 6)
          chk(cyc_a[i+1] - cyc_a[i] - 1 == exp_gap(i), $sformatf("R4 gap step %0d", i),
              cyc_a[i+1] - cyc_a[i] - 1, exp_gap(i));
      end
      chk(done_cyc == cyc_a[6] + TMRD + 1, "R9 init_done cycle", done_cyc, cyc_a[6] + TMRD + 1);
      begin
        int er;
        er = cyc_a[2] + DLL;
        if (done_cyc > er) er = done_cyc;
        chk(rd_cyc == er, "R10 read_ok cycle", rd_cyc, er);
      end
    end
    chk(done_drop == 0, "R9 init_done held", done_drop, 0);
    chk(rd_early == 0, "R10 read_ok before init_done", rd_early, 0);
  endtask

  task automatic mid_abort(input int n);
    mode_cfg = 13'h0155;
    drive_reduced = 1'b1;
    reset_check();
    rst = 1'b0;
    repeat (n) @(negedge clk);
    chk(cke == 1'b1, "R2 cke up before abort", int'(cke), 1);
    reset_check();
  endtask

  initial begin
    logic [AW-1:0] c;
    void'($urandom(32'd20240611));
    // directed corners: bit 8 clear and set, both drive settings
    run_seq(13'h0000, 1'b0, 1'b0);
    run_seq(13'h1FFF, 1'b1, 1'b0);
    mid_abort(STB + 12);
    run_seq(13'h0132, 1'b0, 1'b1);
    for (int r = 0; r < 4; r++) begin
      c = AW'($urandom);
      run_seq(c, 1'($urandom), 1'(r & 1));
    end
    reset_check();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule